// File: doc/BRIEF.md
# HDLC Command Register with Supervision Timer

This block holds the pending commands of one serial channel and runs the supervision timer that goes with them. A host writes command words into it. Each set bit becomes a pending command that stays set until the block has carried it out, and then it clears itself. While any command is still pending, a status flag stays high. The timer counts host-defined tick pulses from a programmable reload value.

The `auto_mode` input selects how the timer is used. With it low, the timer is a general-purpose periodic timer. With it high, the block supports acknowledged HDLC operation. The start command first asks the transmitter for a supervisory frame with the poll bit set, and starts the timer once that frame has been handed over. A sent information frame also starts the timer. A received acknowledge stops it. An expiry raises an interrupt and leaves the timer stopped.

Frame requests leave on a valid/ready channel. `req_valid` rises when a request exists. `req_valid` and the frame kind (`req_poll`) then hold steady until a cycle in which `req_ready` is high, and that cycle is the handover. The transmitter may hold `req_ready` low for as long as it needs to. `auto_mode` is a configuration input and changes only while `busy` is low.

Top module: `hdlc_cmd_timer`

## Requirements
- R1: A write ORs `wr_data` into the pending command bits, and a write never clears a pending bit. The bit positions are: bit 0 start-timer, bit 1 timer-reset, bit 2 send-I-frame.
- R2: After reset, no command is pending, `busy` and `req_valid` are low, and the timer stays inactive (no `timer_irq`) until it is started.
- R3: `busy` is the OR of all pending bits. A timer-reset bit, and a start-timer bit written with `auto_mode` low, stay pending for exactly one cycle.
- R4: With `auto_mode` low, start-timer loads `reload`. On the `reload`-th tick after the start edge, `timer_irq` pulses for one cycle, the value reloads, and counting continues.
- R5: Timer-reset stops the timer. If start-timer and timer-reset are pending together, the timer ends up stopped and no expiry follows.
- R6: With `auto_mode` high, start-timer raises `req_valid` with `req_poll`=1 and stays pending until that request is accepted. The accept edge starts the timer.
- R7: With `auto_mode` high, a pulse on `iframe_sent` starts the timer and a pulse on `ack_rcvd` stops it. Without an acknowledge, one `timer_irq` follows `reload` ticks later and the timer then stays stopped.
- R8: Send-I-frame with `auto_mode` high raises `req_valid` with `req_poll`=0 and stays pending until accepted. With `auto_mode` low, it clears after one cycle and raises no request.
- R9: A request that is not accepted keeps `req_valid` and `req_poll` unchanged. When both frame commands are pending and no request is being held, the poll frame goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 3 | Command word, ORed into the pending bits |
| reload | input | TMR_W | Timer reload value |
| auto_mode | input | 1 | 1 = automatic HDLC mode, 0 = general-purpose timer |
| tick | input | 1 | Timer count enable, one decrement per high cycle |
| iframe_sent | input | 1 | Pulse: an I-frame needing acknowledge was sent |
| ack_rcvd | input | 1 | Pulse: acknowledge received in an I- or S-frame |
| req_ready | input | 1 | Transmitter accepts the presented request |
| req_valid | output | 1 | A frame request is presented |
| req_poll | output | 1 | 1 = S-frame with poll bit, 0 = I-frame |
| busy | output | 1 | At least one command is pending |
| timer_irq | output | 1 | One-cycle pulse on timer expiry |

## Verification
Two things can happen in the same cycle: the timer being started and the timer being stopped. The bench provokes this in two ways. It writes the start and reset bits in one command word while the timer is already running. It also sends an acknowledge two cycles after an `iframe_sent` pulse, so the stop lands while the timer is counting. In both cases the scoreboard expects no interrupt, and any pulse is reported as a failure. Separately, the bench holds a request while a second frame command arrives, and checks that the presented kind does not change and that the accepted kinds come out in the expected order.

// File: rtl/hct_pkg.sv
package hct_pkg;
  localparam int CMD_W     = 3;
  localparam int BIT_START = 0;
  localparam int BIT_HALT  = 1;
  localparam int BIT_SEND  = 2;
  typedef logic [CMD_W-1:0] cmd_t;
endpackage

// File: rtl/hct_cmd_reg.sv
module hct_cmd_reg
  import hct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  cmd_t wr_data,
  input  cmd_t clr,
  input  logic auto_mode,
  output cmd_t pend,
  output logic busy
);
  cmd_t nxt;

  // Per-bit next state: drop on clear, set again by any write (OR-merge)
  for (genvar i = 0; i < CMD_W; i++) begin : g_bit
    assign nxt[i] = (pend[i] & ~clr[i]) | (wr_en & wr_data[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= nxt;
  end

  assign busy = |pend;

  // R1: every bit written is pending on the next cycle
  a_r1_or_merge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((pend & $past(wr_data)) == $past(wr_data)));

  // R3: reset command lives one cycle unless rewritten
  a_r3_halt_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    pend[BIT_HALT] |=> (!pend[BIT_HALT] || $past(wr_en && wr_data[BIT_HALT])));

  // R8: send command is dropped outside automatic mode
  a_r8_send_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[BIT_SEND] && !auto_mode) |=> (!pend[BIT_SEND] || $past(wr_en && wr_data[BIT_SEND])));
endmodule

// File: rtl/hct_req_arb.sv
module hct_req_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_mode,
  input  logic want_poll,
  input  logic want_iframe,
  input  logic req_ready,
  output logic req_valid,
  output logic req_poll,
  output logic acc_poll,
  output logic acc_iframe
);
  logic hold, hold_poll, accept;

  assign req_valid  = auto_mode & (hold | want_poll | want_iframe);
  assign req_poll   = hold ? hold_poll : want_poll;   // poll first when free
  assign accept     = req_valid & req_ready;
  assign acc_poll   = accept & req_poll;
  assign acc_iframe = accept & ~req_poll;

  // Lock the presented kind until the transmitter takes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= 1'b0;
      hold_poll <= 1'b0;
    end else if (!auto_mode || accept) begin
      hold      <= 1'b0;
    end else if (req_valid) begin
      hold      <= 1'b1;
      hold_poll <= req_poll;
    end
  end

  // R9: a stalled request keeps its kind
  a_r9_hold_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && auto_mode) |=>
      (!auto_mode || (req_valid && req_poll == $past(req_poll))));
endmodule

// File: rtl/hct_timer.sv
module hct_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  input  logic             one_shot,
  input  logic [TMR_W-1:0] reload,
  output logic             irq
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic             run;
  logic [TMR_W-1:0] cnt;
  logic             last;

  assign last = (cnt <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stop) begin
        run <= 1'b0;                 // stop outranks start
      end else if (start) begin
        run <= 1'b1;
        cnt <= reload;
      end else if (run && tick) begin
        if (last) begin
          irq <= 1'b1;
          if (one_shot) run <= 1'b0;
          else          cnt <= reload;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  // R5: a stop request always leaves the timer idle
  a_r5_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !run);

  // R7: automatic mode halts after an expiry
  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && last && one_shot && !start && !stop) |=> (!run && irq));

  // R4: an interrupt only comes from a running timer that saw a tick
  a_r4_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run && tick));
endmodule

// File: rtl/hdlc_cmd_timer.sv
module hdlc_cmd_timer
  import hct_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_data,
  input  logic [TMR_W-1:0] reload,
  input  logic             auto_mode,
  input  logic             tick,
  input  logic             iframe_sent,
  input  logic             ack_rcvd,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             req_poll,
  output logic             busy,
  output logic             timer_irq
);
  cmd_t pend, clr;
  logic acc_poll, acc_iframe;
  logic t_start, t_stop;

  hct_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clr(clr), .auto_mode(auto_mode), .pend(pend), .busy(busy)
  );

  hct_req_arb u_arb (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode),
    .want_poll(pend[BIT_START]), .want_iframe(pend[BIT_SEND]),
    .req_ready(req_ready), .req_valid(req_valid), .req_poll(req_poll),
    .acc_poll(acc_poll), .acc_iframe(acc_iframe)
  );

  // Frame commands wait for the handover in auto mode; all else clears at once
  always_comb begin
    clr            = '0;
    clr[BIT_START] = pend[BIT_START] & (auto_mode ? acc_poll : 1'b1);
    clr[BIT_HALT]  = pend[BIT_HALT];
    clr[BIT_SEND]  = pend[BIT_SEND] & (auto_mode ? acc_iframe : 1'b1);
  end

  assign t_start = auto_mode ? (acc_poll | iframe_sent) : pend[BIT_START];
  assign t_stop  = pend[BIT_HALT] | (auto_mode & ack_rcvd);

  hct_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(t_start), .stop(t_stop),
    .tick(tick), .one_shot(auto_mode), .reload(reload), .irq(timer_irq)
  );

  // R6: a pending poll command in auto mode is always presented
  a_r6_poll_presented: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && pend[BIT_START]) |-> req_valid);
endmodule

// File: tb/hdlc_cmd_timer_test.sv
`timescale 1ns/1ps
module hdlc_cmd_timer_test;
  localparam int TW = 16;
  localparam int RL = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic [TW-1:0] reload = TW'(RL);
  logic auto_mode = 1'b0, tick = 1'b1, iframe_sent = 1'b0, ack_rcvd = 1'b0, req_ready = 1'b0;
  logic req_valid, req_poll, busy, timer_irq;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 1'b0;
  int exp_irq[$];
  bit exp_req[$];

  hdlc_cmd_timer #(.TMR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .reload(reload),
    .auto_mode(auto_mode), .tick(tick), .iframe_sent(iframe_sent), .ack_rcvd(ack_rcvd),
    .req_ready(req_ready), .req_valid(req_valid), .req_poll(req_poll),
    .busy(busy), .timer_irq(timer_irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic wr(input logic [2:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops scoreboard entries as results appear
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (timer_irq) begin
        n_chk++;
        if (exp_irq.size() == 0) begin
          n_err++;
          $display("FAIL R4 R5 R7 unexpected irq: actual=%0d expected=none", cyc);
        end else begin
          int e;
          e = exp_irq.pop_front();
          if (e != cyc) begin
            n_err++;
            $display("FAIL R4 R7 irq cycle: actual=%0d expected=%0d", cyc, e);
          end
        end
      end
      if (req_valid && req_ready) begin
        n_chk++;
        if (exp_req.size() == 0) begin
          n_err++;
          $display("FAIL R6 R8 unexpected accept: actual=%0d expected=none", req_poll);
        end else begin
          bit k;
          k = exp_req.pop_front();
          if (k != req_poll) begin
            n_err++;
            $display("FAIL R9 accepted kind: actual=%0d expected=%0d", req_poll, k);
          end
        end
      end
    end
  end

  initial begin
    #(4 * 50000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int c, a;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state, timer idle despite ticks
    check("R2", "busy", busy, 0);
    check("R2", "req_valid", req_valid, 0);
    check("R2", "timer_irq", timer_irq, 0);
    idle(3 * RL);

    // R4 R3: periodic timer, then stopped by reset command (R5)
    c = cyc;
    exp_irq.push_back(c + 2 + RL);
    exp_irq.push_back(c + 2 + 2 * RL);
    wr(3'b001);
    check("R3", "busy after start write", busy, 1);
    @(negedge clk);
    check("R3", "start bit self-clears", busy, 0);
    wait_cyc(c + 2 + 2 * RL);
    wr(3'b010);
    check("R3", "busy with reset bit", busy, 1);
    idle(4 * RL);
    check("R4", "periodic irqs seen", exp_irq.size(), 0);

    // R5: start and reset pending together while running
    wr(3'b001);
    @(negedge clk);
    wr(3'b011);
    check("R5", "busy on combined write", busy, 1);
    idle(3 * RL);

    // R8: send command outside auto mode
    wr(3'b100);
    check("R8", "no request in manual mode", req_valid, 0);
    check("R8", "send pending one cycle", busy, 1);
    @(negedge clk);
    check("R8", "send dropped", busy, 0);

    // R6: poll request in auto mode
    auto_mode = 1'b1;
    @(negedge clk);
    wr(3'b001);
    check("R6", "req_valid", req_valid, 1);
    check("R6", "req_poll", req_poll, 1);
    idle(3);
    check("R6", "still pending under back-pressure", busy, 1);
    check("R9", "kind stable while stalled", req_poll, 1);
    a = cyc;
    req_ready = 1'b1;
    exp_req.push_back(1'b1);
    exp_irq.push_back(a + 1 + RL);
    @(negedge clk);
    req_ready = 1'b0;
    check("R6", "start bit cleared on accept", busy, 0);
    check("R6", "request gone", req_valid, 0);
    idle(4 * RL);
    check("R7", "single auto expiry", exp_irq.size(), 0);

    // R7: I-frame sent then acknowledged -> no expiry
    iframe_sent = 1'b1;
    @(negedge clk);
    iframe_sent = 1'b0;
    @(negedge clk);
    ack_rcvd = 1'b1;
    @(negedge clk);
    ack_rcvd = 1'b0;
    idle(3 * RL);
    // R7: I-frame sent, no acknowledge -> expiry
    c = cyc;
    exp_irq.push_back(c + 1 + RL);
    iframe_sent = 1'b1;
    @(negedge clk);
    iframe_sent = 1'b0;
    idle(4 * RL);
    check("R7", "unacknowledged expiry", exp_irq.size(), 0);

    // R1 R9: held I-frame request survives later writes
    wr(3'b100);
    check("R8", "I-frame request", req_valid, 1);
    check("R8", "I-frame kind", req_poll, 0);
    wr(3'b010);
    check("R1", "reset write keeps send pending", req_valid, 1);
    wr(3'b001);
    check("R9", "held kind unchanged", req_poll, 0);
    a = cyc;
    req_ready = 1'b1;
    exp_req.push_back(1'b0);
    @(negedge clk);
    check("R9", "poll follows", req_poll, 1);
    exp_req.push_back(1'b1);
    exp_irq.push_back(a + 2 + RL);
    @(negedge clk);
    req_ready = 1'b0;
    check("R1", "all merged commands done", busy, 0);
    idle(3 * RL);

    // R9: both written at once -> poll first
    wr(3'b101);
    check("R9", "poll first", req_poll, 1);
    a = cyc;
    req_ready = 1'b1;
    exp_req.push_back(1'b1);
    exp_irq.push_back(a + 1 + RL);
    @(negedge clk);
    exp_req.push_back(1'b0);
    @(negedge clk);
    req_ready = 1'b0;
    idle(3 * RL);

    check("R9", "accept queue drained", exp_req.size(), 0);
    check("R7", "irq queue drained", exp_irq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule